// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file that sits behind a simple 32-bit read/write bus on a development-board FPGA. It drives an eight-lamp LED bar, an eight-character text display, a general-purpose output byte and a pair of bit-banged I2C lines toward a serial memory. It also issues a one-cycle system reset request.

Software can fill the display in two ways. One way is to write a full 32-bit word, which the block renders as eight uppercase hexadecimal characters. The other way is to write one character at a time through eight per-position registers placed at an 8-byte stride.

The block decodes only the low 20 bits of the bus address. Any access to an offset it does not define is flagged with a one-cycle error pulse and changes nothing. Reads are registered, so read data appears in the cycle after the read strobe and holds until the next read.

Top module: `board_ctrl_regs`

Register offsets (low 20 bits of the address):

| Offset | Register | Access |
|---|---|---|
| 0x00000 | Switch | Reads 0 |
| 0x00008 | LED bar | Read/write, 8 bits |
| 0x00010 | General-purpose output | Read/write, 8 bits |
| 0x00410 | Hex word | Write-only |
| 0x00418 + 8*i | Display character i, for i = 0..7 | Read/write |
| 0x00500 | Soft reset | Write-only |
| 0x00B00 | I2C output enable | Read/write, 2 bits |
| 0x00B08 | I2C input | Read-only |
| 0x00B10 | I2C output | Read/write, 2 bits |
| 0x00B18 | I2C select | Read/write, 1 bit |

## Requirements
- R1: After reset, all eight display characters are 0x20 (space). `ledBar`, `gpOut`, `i2cOutEn`, `i2cSel`, `sclOut`, `sdaOut`, `resetReq`, `busErr` and `busRdData` are all zero.
- R2: Only address bits 19:0 are decoded, so bits above 19 are ignored. A read or write to any offset not in the map, including 0x41C and other offsets between the character registers, raises `busErr` for the one cycle after the access. Such an access changes no register, and a read of it returns 0.
- R3: The switch register at 0x00000 always reads 0. Writes to it are accepted without error.
- R4: A write to the LED bar at 0x00008 with byte lane 0 enabled stores data bits 7:0 on `ledBar`, and a read returns them zero-extended. A write with lane 0 disabled changes nothing.
- R5: A write to the hex word register at 0x00410 renders the data as uppercase hex ASCII, using '0'-'9' and 'A'-'F'. Character 0 receives nibble 31:28 and character 7 receives nibble 3:0. Byte lane k updates only the two characters 6-2k and 7-2k.
- R6: A write with lane 0 enabled to 0x00418 + 8*i stores data bits 7:0 as character i. A read of that offset returns the character. On `dispChars`, character i appears at bits 8*i+7:8*i.
- R7: A write with lane 0 enabled to the soft-reset register at 0x00500 makes `resetReq` high for exactly the one cycle after the write.
- R8: The general-purpose output register at 0x00010 stores data bits 7:0 on `gpOut` and reads them back.
- R9: The I2C output-enable register at 0x00B00 keeps data bits 1:0 on `i2cOutEn`. The I2C select register at 0x00B18 keeps data bit 0 on `i2cSel`. Both read back zero-extended.
- R10: A write to the I2C output register at 0x00B10 drives `sclOut` from data bit 1 and `sdaOut` from data bit 0. A read returns those two bits.
- R11: A read of the I2C input register at 0x00B08 returns the stored SCL bit in bit 1 and the live `i2cSdaIn` in bit 0, with all other bits zero. Writes to this register change nothing.
- R12: Reads of the write-only hex word and soft-reset registers return 0.
- R13: `busRdData` updates only in the cycle after `busRdEn` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address; low 20 bits decoded |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busByteEn | input | 4 | Write byte-lane mask |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle pulse after an access to an undefined offset |
| ledBar | output | 8 | LED bar state |
| dispChars | output | 64 | Eight display characters, character i at bits 8i+7:8i |
| gpOut | output | 8 | General-purpose output byte |
| i2cOutEn | output | 2 | I2C output enables |
| i2cSel | output | 1 | I2C bus select |
| sclOut | output | 1 | I2C clock line drive |
| sdaOut | output | 1 | I2C data line drive |
| i2cSdaIn | input | 1 | Data line value returned by the attached slave |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench probes several corner cases:
- **Gap inside the character window.** It accesses offset 0x41C. A decoder that masked only the window bounds would silently overwrite character 0 or 1 instead of raising the error.
- **Partial-lane hex-word write.** A design with the nibble-to-position order reversed, or one that ignored the lane mask, would put the wrong characters on the display.
- **Ignored address bits.** It addresses the LED register with the upper address bits set. A full-width decoder would report an error there.
- **I2C input merge and soft reset.** It flips the slave's data line between reads, which exposes a design that returns the stored bit instead of the live one. It also watches the soft-reset pulse for one cycle only, which catches a level that sticks.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  // Bus data width and derived counts.
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int NUM_CHARS  = DATA_W / 4;          // one character per nibble
  localparam int CHAR_IDX_W = $clog2(NUM_CHARS);

  // Decoded offset width and character window geometry.
  localparam int DEC_W      = 20;
  localparam int STRIDE_SH  = 3;                    // 8-byte stride
  localparam int CHAR_STRIDE = 1 << STRIDE_SH;

  localparam logic [DEC_W-1:0] OFF_SWITCH  = 20'h00000;
  localparam logic [DEC_W-1:0] OFF_LED     = 20'h00008;
  localparam logic [DEC_W-1:0] OFF_GP      = 20'h00010;
  localparam logic [DEC_W-1:0] OFF_WORD    = 20'h00410;
  localparam logic [DEC_W-1:0] OFF_CHAR0   = 20'h00418;
  localparam logic [DEC_W-1:0] OFF_SOFTRES = 20'h00500;
  localparam logic [DEC_W-1:0] OFF_I2C_OE  = 20'h00B00;
  localparam logic [DEC_W-1:0] OFF_I2C_IN  = 20'h00B08;
  localparam logic [DEC_W-1:0] OFF_I2C_OUT = 20'h00B10;
  localparam logic [DEC_W-1:0] OFF_I2C_SEL = 20'h00B18;
  localparam logic [DEC_W-1:0] CHAR_SPAN   = DEC_W'(NUM_CHARS * CHAR_STRIDE);

  localparam logic [7:0] ASCII_SPACE = 8'h20;

  typedef enum logic [2:0] {
    RD_ZERO, RD_LED, RD_GP, RD_CHAR, RD_I2C_OE, RD_I2C_IN, RD_I2C_OUT, RD_I2C_SEL
  } rdSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic                  wrLed;
    logic                  wrGp;
    logic                  wrWord;
    logic                  wrChar;
    logic [CHAR_IDX_W-1:0] charIdx;
    logic                  wrSoftRes;
    logic                  wrI2cOe;
    logic                  wrI2cOut;
    logic                  wrI2cSel;
    logic [BE_W-1:0]       lanes;
    logic                  rdLoad;
    rdSel_e                rdSel;
  } strobes_t;

endpackage

// File: rtl/board_ctrl_hexchar.sv
module board_ctrl_hexchar (
  input  logic [3:0] nib,
  output logic [7:0] ascii
);
  // '0'..'9' then 'A'..'F' (0x41 - 10 = 0x37)
  always_comb begin
    if (nib < 4'd10) ascii = 8'h30 + {4'b0, nib};
    else             ascii = 8'h37 + {4'b0, nib};
  end
endmodule

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BE_W-1:0]   busByteEn,
  output strobes_t          strb,
  output logic              busErr
);
  logic [DEC_W-1:0] off;
  logic [DEC_W-1:0] charRel;
  logic             charHit;
  logic             known;
  logic             wrLane0;
  logic             unusedAddrHi;
  logic             errQ;

  assign off          = busAddr[DEC_W-1:0];
  assign unusedAddrHi = ^busAddr[ADDR_W-1:DEC_W];
  assign charRel      = off - OFF_CHAR0;
  assign charHit      = (off >= OFF_CHAR0) && (charRel < CHAR_SPAN) &&
                        (charRel[STRIDE_SH-1:0] == '0);
  assign wrLane0      = busWrEn & busByteEn[0];

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    strb.lanes   = busByteEn;
    strb.rdLoad  = busRdEn;
    strb.charIdx = charRel[STRIDE_SH +: CHAR_IDX_W];
    known        = 1'b1;
    case (off)
      OFF_SWITCH:  ;
      OFF_LED:     begin strb.wrLed = wrLane0;    strb.rdSel = RD_LED;     end
      OFF_GP:      begin strb.wrGp = wrLane0;     strb.rdSel = RD_GP;      end
      OFF_WORD:    strb.wrWord = busWrEn & (|busByteEn);
      OFF_SOFTRES: strb.wrSoftRes = wrLane0;
      OFF_I2C_OE:  begin strb.wrI2cOe = wrLane0;  strb.rdSel = RD_I2C_OE;  end
      OFF_I2C_IN:  strb.rdSel = RD_I2C_IN;
      OFF_I2C_OUT: begin strb.wrI2cOut = wrLane0; strb.rdSel = RD_I2C_OUT; end
      OFF_I2C_SEL: begin strb.wrI2cSel = wrLane0; strb.rdSel = RD_I2C_SEL; end
      default: begin
        if (charHit) begin
          strb.wrChar = wrLane0;
          strb.rdSel  = RD_CHAR;
        end else begin
          known = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= (busWrEn | busRdEn) & ~known;
  end

  assign busErr = errQ;
endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strb,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   i2cSdaIn,
  output logic [DATA_W-1:0]      rdData,
  output logic [7:0]             ledBar,
  output logic [8*NUM_CHARS-1:0] dispChars,
  output logic [7:0]             gpOut,
  output logic [1:0]             i2cOutEn,
  output logic                   i2cSel,
  output logic                   sclOut,
  output logic                   sdaOut,
  output logic                   resetReq
);
  logic [7:0]        ledQ, gpQ;
  logic [1:0]        i2cOeQ, i2cOutQ;
  logic              i2cSelQ, softResQ;
  logic [7:0]        charQ [NUM_CHARS];
  logic [DATA_W-1:0] rdQ, rdNext;

  // Per-character storage; character i takes nibble NUM_CHARS-1-i.
  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
    localparam int NIB  = NUM_CHARS - 1 - i;
    localparam int LANE = NIB / 2;
    logic [7:0] hexAscii;

    board_ctrl_hexchar u_hex (
      .nib   (wrData[4*NIB +: 4]),
      .ascii (hexAscii)
    );

    always_ff @(posedge clk) begin
      if (!rstN)
        charQ[i] <= ASCII_SPACE;
      else if (strb.wrWord && strb.lanes[LANE])
        charQ[i] <= hexAscii;
      else if (strb.wrChar && (strb.charIdx == CHAR_IDX_W'(i)))
        charQ[i] <= wrData[7:0];
    end

    assign dispChars[8*i +: 8] = charQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledQ     <= '0;
      gpQ      <= '0;
      i2cOeQ   <= '0;
      i2cOutQ  <= '0;
      i2cSelQ  <= 1'b0;
      softResQ <= 1'b0;
    end else begin
      if (strb.wrLed)    ledQ    <= wrData[7:0];
      if (strb.wrGp)     gpQ     <= wrData[7:0];
      if (strb.wrI2cOe)  i2cOeQ  <= wrData[1:0];
      if (strb.wrI2cOut) i2cOutQ <= wrData[1:0];
      if (strb.wrI2cSel) i2cSelQ <= wrData[0];
      softResQ <= strb.wrSoftRes;
    end
  end

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_LED:     rdNext[7:0] = ledQ;
      RD_GP:      rdNext[7:0] = gpQ;
      RD_CHAR:    rdNext[7:0] = charQ[strb.charIdx];
      RD_I2C_OE:  rdNext[1:0] = i2cOeQ;
      RD_I2C_IN:  rdNext[1:0] = {i2cOutQ[1], i2cSdaIn};
      RD_I2C_OUT: rdNext[1:0] = i2cOutQ;
      RD_I2C_SEL: rdNext[0]   = i2cSelQ;
      default:    rdNext      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdQ <= '0;
    else if (strb.rdLoad) rdQ <= rdNext;
  end

  assign rdData   = rdQ;
  assign ledBar   = ledQ;
  assign gpOut    = gpQ;
  assign i2cOutEn = i2cOeQ;
  assign i2cSel   = i2cSelQ;
  assign sclOut   = i2cOutQ[1];
  assign sdaOut   = i2cOutQ[0];
  assign resetReq = softResQ;
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [BE_W-1:0]        busByteEn,
  input  logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W-1:0]      busRdData,
  output logic                   busErr,
  output logic [7:0]             ledBar,
  output logic [8*NUM_CHARS-1:0] dispChars,
  output logic [7:0]             gpOut,
  output logic [1:0]             i2cOutEn,
  output logic                   i2cSel,
  output logic                   sclOut,
  output logic                   sdaOut,
  input  logic                   i2cSdaIn,
  output logic                   resetReq
);
  strobes_t strb;

  board_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busByteEn (busByteEn),
    .strb      (strb),
    .busErr    (busErr)
  );

  board_ctrl_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .i2cSdaIn  (i2cSdaIn),
    .rdData    (busRdData),
    .ledBar    (ledBar),
    .dispChars (dispChars),
    .gpOut     (gpOut),
    .i2cOutEn  (i2cOutEn),
    .i2cSel    (i2cSel),
    .sclOut    (sclOut),
    .sdaOut    (sdaOut),
    .resetReq  (resetReq)
  );
endmodule

// File: rtl/board_ctrl_checker.sv
module board_ctrl_checker
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWrEn,
  input logic                   busRdEn,
  input logic [BE_W-1:0]        busByteEn,
  input logic [DATA_W-1:0]      busRdData,
  input logic                   busErr,
  input logic [7:0]             ledBar,
  input logic [8*NUM_CHARS-1:0] dispChars,
  input logic [7:0]             gpOut,
  input logic [1:0]             i2cOutEn,
  input logic                   i2cSel,
  input logic                   sclOut,
  input logic                   sdaOut,
  input logic                   resetReq
);
  logic softResWr;
  assign softResWr = busWrEn && busByteEn[0] && (busAddr[DEC_W-1:0] == OFF_SOFTRES);

  // R7: a soft-reset write yields the request next cycle
  a_r7_reset_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    softResWr |=> resetReq);

  // R7: no request without a soft-reset write the cycle before
  a_r7_reset_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(softResWr));

  // R2: the error pulse always follows a bus access
  a_r2_err_has_access: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWrEn || busRdEn));

  // R4: LED bar holds without a write
  a_r4_led_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(ledBar));

  // R5, R6: characters hold without a write
  a_r6_chars_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(dispChars));

  // R8, R9, R10: output registers hold without a write
  a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable({gpOut, i2cOutEn, i2cSel, sclOut, sdaOut}));

  // R13: read data holds without a read strobe
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

bind board_ctrl_regs board_ctrl_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busByteEn (busByteEn),
  .busRdData (busRdData),
  .busErr    (busErr),
  .ledBar    (ledBar),
  .dispChars (dispChars),
  .gpOut     (gpOut),
  .i2cOutEn  (i2cOutEn),
  .i2cSel    (i2cSel),
  .sclOut    (sclOut),
  .sdaOut    (sdaOut),
  .resetReq  (resetReq)
);

// File: tb/tb_board_ctrl_regs.sv
`timescale 1ns/1ps
module tb_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busErr;
  logic [7:0]  ledBar;
  logic [63:0] dispChars;
  logic [7:0]  gpOut;
  logic [1:0]  i2cOutEn;
  logic        i2cSel, sclOut, sdaOut;
  logic        i2cSdaIn = 1'b0;
  logic        resetReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdSeen = 1'b0;
  logic [63:0] expChars;

  always #2.5 clk = ~clk;

  board_ctrl_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData), .busErr(busErr),
    .ledBar(ledBar), .dispChars(dispChars), .gpOut(gpOut), .i2cOutEn(i2cOutEn),
    .i2cSel(i2cSel), .sclOut(sclOut), .sdaOut(sdaOut), .i2cSdaIn(i2cSdaIn),
    .resetReq(resetReq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? 8'd48 + 8'(n) : 8'd65 + 8'(n) - 8'd10;
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Driver: pushes the expected value, the monitor compares it.
  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  always @(posedge clk) rdSeen <= busRdEn;

  // Monitor
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(t, 64'(busRdData), 64'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ledBar", 64'(ledBar), 0);
    chk("R1 dispChars", dispChars, {8{8'h20}});
    chk("R1 gpOut", 64'(gpOut), 0);
    chk("R1 i2c", 64'({i2cOutEn, i2cSel, sclOut, sdaOut}), 0);
    chk("R1 resetReq/busErr", 64'({resetReq, busErr}), 0);
    chk("R1 busRdData", 64'(busRdData), 0);

    // R3 switch
    wr(32'h0, 32'hFFFF_FFFF, 4'hF);
    chk("R3 no error on switch write", 64'(busErr), 0);
    rd(32'h0, 32'h0, "R3 switch read");

    // R4 LED bar, lane mask
    wr(32'h8, 32'hABCD_12A5, 4'hF);
    chk("R4 ledBar", 64'(ledBar), 64'hA5);
    rd(32'h8, 32'hA5, "R4 led read");
    wr(32'h8, 32'h0000_0033, 4'b1110);
    chk("R4 lane0 off ignored", 64'(ledBar), 64'hA5);

    // R2 upper address bits ignored
    wr(32'hFFF0_0008, 32'h5C, 4'h1);
    chk("R2 upper bits ignored", 64'(ledBar), 64'h5C);
    chk("R2 no error", 64'(busErr), 0);

    // R5 hex word render
    wr(32'h410, 32'h1234_ABCF, 4'hF);
    expChars = '0;
    for (int i = 0; i < 8; i++) expChars[8*i +: 8] = hexc(4'(32'h1234_ABCF >> (28 - 4*i)));
    chk("R5 full word", dispChars, expChars);
    wr(32'h410, 32'h9E0F_5A7D, 4'b0001);
    expChars[8*6 +: 8] = "7";
    expChars[8*7 +: 8] = "D";
    chk("R5 lane0 only", dispChars, expChars);
    wr(32'h410, 32'h9E0F_5A7D, 4'b1000);
    expChars[8*0 +: 8] = "9";
    expChars[8*1 +: 8] = "E";
    chk("R5 lane3 only", dispChars, expChars);
    rd(32'h410, 32'h0, "R12 word reads zero");

    // R6 per-character writes
    wr(32'h430, 32'hFFFF_FF5A, 4'h1);
    expChars[8*3 +: 8] = 8'h5A;
    chk("R6 char3", dispChars, expChars);
    rd(32'h430, 32'h5A, "R6 char3 read");
    wr(32'h450, 32'h0000_0021, 4'h1);
    expChars[8*7 +: 8] = 8'h21;
    chk("R6 char7", dispChars, expChars);
    rd(32'h418, 32'h39, "R6 char0 read");

    // R2 undefined offsets
    wr(32'h41C, 32'h0000_0055, 4'h1);
    chk("R2 gap error", 64'(busErr), 1);
    chk("R2 gap no change", dispChars, expChars);
    @(negedge clk);
    chk("R2 error one cycle", 64'(busErr), 0);
    rd(32'h4, 32'h0, "R2 undefined read zero");
    chk("R2 read error", 64'(busErr), 1);
    wr(32'h458, 32'h1, 4'h1);
    chk("R2 past window error", 64'(busErr), 1);

    // R7 soft reset pulse
    chk("R7 idle", 64'(resetReq), 0);
    wr(32'h500, 32'h1, 4'h1);
    chk("R7 pulse high", 64'(resetReq), 1);
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(resetReq), 0);
    rd(32'h500, 32'h0, "R12 softres reads zero");

    // R8 GP output
    wr(32'h10, 32'h1234_563C, 4'hF);
    chk("R8 gpOut", 64'(gpOut), 64'h3C);
    rd(32'h10, 32'h3C, "R8 gp read");

    // R9 I2C OE and select
    wr(32'hB00, 32'hFF, 4'h1);
    chk("R9 oe", 64'(i2cOutEn), 3);
    wr(32'hB18, 32'hFF, 4'h1);
    chk("R9 sel", 64'(i2cSel), 1);
    rd(32'hB00, 32'h3, "R9 oe read");
    rd(32'hB18, 32'h1, "R9 sel read");

    // R10 I2C out
    wr(32'hB10, 32'h2, 4'h1);
    chk("R10 scl/sda", 64'({sclOut, sdaOut}), 64'b10);
    rd(32'hB10, 32'h2, "R10 out read");
    wr(32'hB10, 32'h1, 4'h1);
    chk("R10 scl/sda swap", 64'({sclOut, sdaOut}), 64'b01);

    // R11 I2C input merge
    wr(32'hB10, 32'h2, 4'h1);
    i2cSdaIn = 1'b1;
    rd(32'hB08, 32'h3, "R11 in sda=1");
    i2cSdaIn = 1'b0;
    rd(32'hB08, 32'h2, "R11 in sda=0");
    wr(32'hB08, 32'hFF, 4'hF);
    chk("R11 write ignored", 64'({sclOut, sdaOut, i2cOutEn, i2cSel}), 64'b10111);
    chk("R11 no error", 64'(busErr), 0);
    rd(32'hB08, 32'h2, "R11 in after write");

    // R13 read data holds
    repeat (3) @(negedge clk);
    chk("R13 rdData holds", 64'(busRdData), 64'h2);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule